// File: doc/BRIEF.md
# Audio Clock Ratio Detector

This block runs on the master clock of an audio converter and watches the frame (left/right) clock. It measures how many master clock cycles pass between two rising frame clock edges. It then compares that count with a fixed set of oversampling ratios, each with a tolerance window. It reports four things:

- the ratio it found, as a code;
- whether it is locked to that ratio;
- whether the signal-processing chain must run at the reduced 64fs oversample rate;
- a hold request, which tells the data path to keep its last sample while no valid ratio is present.

Two copies are used. The playback copy is built with `PLAY_PATH=1` and accepts every ratio. The record copy is built with `PLAY_PATH=0`. It rejects the two lowest ratios and has an input that forces the 64fs rate, which is meant for high sample rate recording.

The frame clock input passes through a synchroniser before it is used. A frame clock that stops, or is absent, is detected through a saturating period counter, so the lock drops instead of the counter wrapping.

Top module: `clk_ratio_detect`

## Requirements
- R1: The frame clock passes through two synchronising flops. A period is the number of master clock cycles from one rising frame clock edge to the next rising edge.
- R2: The ratio code encodes 3'b000=128, 3'b001=192, 3'b010=256, 3'b011=384, 3'b100=512 and 3'b101=768 master clocks per frame.
- R3: A period matches a ratio when it lies within TOL (default 32) cycles of it, both ends included. For example, 96 and 800 match, while 95 and 801 match nothing.
- R4: Where two tolerance windows overlap, the ratio with the lower code wins. A period of 160 gives 3'b000 and a period of 224 gives 3'b001 on the playback path.
- R5: With `PLAY_PATH=0`, the 128 and 192 ratios are never matched. A period of 224 then gives 3'b010, and a period of 160 matches nothing.
- R6: `locked` rises only after two consecutive measured periods classify to the same ratio. It falls on the first period that is unmatched or that classifies to a different ratio. `ratio_code` is updated only when lock is gained.
- R7: `hold_req` is high whenever `locked` is low. While the block is unlocked, `ratio_code` keeps the last locked value.
- R8: With `PLAY_PATH=1`, `osr64` is high exactly when the block is locked at code 3'b000 or 3'b001.
- R9: With `PLAY_PATH=0`, `osr64` follows the `force_osr64` input.
- R10: The period counter saturates at 2**CNT_W-1 cycles, which is 1023 by default. If no rising edge arrives for that long, the result counts as an unmatched period and the lock drops.
- R11: After reset, `locked` is 0, `hold_req` is 1, `ratio_code` is 3'b000, and `osr64` is 0 when `force_osr64` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_clk | input | 1 | Asynchronous frame (left/right) clock |
| force_osr64 | input | 1 | Record path only: force the 64fs oversample rate |
| ratio_code | output | 3 | Last locked ratio code |
| locked | output | 1 | Ratio lock flag |
| osr64 | output | 1 | Signal processing runs at 64fs (otherwise 128fs) |
| hold_req | output | 1 | Mute/hold request while unlocked |

## Verification
The bench builds two copies side by side and drives both from one frame clock. The first copy uses `PLAY_PATH=1` and the second uses `PLAY_PATH=0`, so every period is judged against both ratio sets. This brings the rejection of the low ratios and the forced 64fs input within reach in the same runs. Both copies keep `CNT_W=10`, which puts the saturation limit of a stopped frame clock (1023 cycles) within a short directed run. They also keep `TOL=32`, which places the window edges and the overlaps at 160 and 224 where directed periods can hit them exactly.

// File: rtl/crd_pkg.sv
package crd_pkg;

    localparam int unsigned NUM_RATIOS = 6;

    typedef enum logic [2:0] {
        RC_128  = 3'd0,
        RC_192  = 3'd1,
        RC_256  = 3'd2,
        RC_384  = 3'd3,
        RC_512  = 3'd4,
        RC_768  = 3'd5,
        RC_NONE = 3'd7
    } ratio_code_e;

    typedef struct packed {
        logic        hit;
        ratio_code_e code;
    } class_res_t;

    // Master clocks per frame for a ratio index: odd indices are 1.5x, doubling every two steps.
    function automatic int unsigned ratio_cycles(input int unsigned idx);
        int unsigned base;
        base = idx[0] ? 32'd192 : 32'd128;
        return base << (idx >> 1);
    endfunction

    // Lowest index wins where windows overlap.
    function automatic class_res_t classify(input int unsigned period,
                                            input logic        play,
                                            input int unsigned tol);
        class_res_t  res;
        int unsigned r;
        res.hit  = 1'b0;
        res.code = RC_NONE;
        for (int unsigned i = 0; i < NUM_RATIOS; i++) begin
            r = ratio_cycles(i);
            if (!res.hit && (play || i >= 2) &&
                (period + tol >= r) && (period <= r + tol)) begin
                res.hit  = 1'b1;
                res.code = ratio_code_e'(i[2:0]);
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/crd_sync.sv
module crd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/crd_period_meter.sv
module crd_period_meter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_period
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             lvl_d;
    logic             armed;
    logic             rise;
    logic [CNT_W-1:0] cnt;

    assign rise = lvl & ~lvl_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_d       <= 1'b0;
            armed       <= 1'b0;
            cnt         <= '0;
            meas_valid  <= 1'b0;
            meas_period <= '0;
        end else begin
            lvl_d      <= lvl;
            meas_valid <= 1'b0;
            if (rise) begin
                armed <= 1'b1;
                cnt   <= '0;
                if (armed) begin
                    meas_valid  <= 1'b1;
                    meas_period <= (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
                end
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
                if (cnt == CNT_MAX - 1'b1) begin
                    meas_valid  <= 1'b1;
                    meas_period <= CNT_MAX;
                end
            end
        end
    end
endmodule

// File: rtl/crd_lock_tracker.sv
module crd_lock_tracker
    import crd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        meas_valid,
    input  class_res_t  res,
    output logic        locked,
    output ratio_code_e held_code
);
    logic        cand_ok;
    ratio_code_e cand;

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_ok   <= 1'b0;
            cand      <= RC_NONE;
            locked    <= 1'b0;
            held_code <= RC_128;
        end else if (meas_valid) begin
            if (res.hit) begin
                cand    <= res.code;
                cand_ok <= 1'b1;
                if (cand_ok && cand == res.code) begin
                    locked    <= 1'b1;
                    held_code <= res.code;
                end else begin
                    locked <= 1'b0;
                end
            end else begin
                cand_ok <= 1'b0;
                locked  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect
    import crd_pkg::*;
#(
    parameter bit PLAY_PATH = 1'b1,
    parameter int CNT_W     = 10,
    parameter int TOL       = 32,
    parameter int SYNC_LEN  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_clk,
    input  logic       force_osr64,
    output logic [2:0] ratio_code,
    output logic       locked,
    output logic       osr64,
    output logic       hold_req
);
    logic             fclk_s;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_period;
    class_res_t       res;
    ratio_code_e      held_code;

    crd_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (frame_clk),
        .q   (fclk_s)
    );

    crd_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk         (clk),
        .rst         (rst),
        .lvl         (fclk_s),
        .meas_valid  (meas_valid),
        .meas_period (meas_period)
    );

    always_comb res = classify(int'(meas_period), PLAY_PATH, TOL);

    crd_lock_tracker u_lock (
        .clk        (clk),
        .rst        (rst),
        .meas_valid (meas_valid),
        .res        (res),
        .locked     (locked),
        .held_code  (held_code)
    );

    assign ratio_code = held_code;
    assign hold_req   = ~locked;

    generate
        if (PLAY_PATH) begin : g_play
            assign osr64 = locked & (held_code == RC_128 || held_code == RC_192);
        end else begin : g_rec
            assign osr64 = force_osr64;
        end
    endgenerate
endmodule

// File: rtl/clk_ratio_detect_chk.sv
module clk_ratio_detect_chk #(
    parameter bit PLAY_PATH = 1'b1,
    parameter int CNT_W     = 10,
    parameter int TOL       = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       ratio_code,
    input logic             locked,
    input logic             osr64,
    input logic             meas_valid,
    input logic [CNT_W-1:0] meas_period
);
    localparam int unsigned FAR_LIMIT = 768 + TOL;

    assert_code_only_on_meas_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(meas_valid) |-> $stable(ratio_code));

    assert_lock_after_meas_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(meas_valid));

    assert_far_period_unlocks_R10: assert property (@(posedge clk) disable iff (rst)
        (meas_valid && int'(meas_period) > FAR_LIMIT) |=> !locked);

    assert_rec_no_low_code_R5: assert property (@(posedge clk) disable iff (rst)
        (!PLAY_PATH && locked) |-> (ratio_code >= 3'd2));

    assert_play_osr_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (PLAY_PATH && osr64) |-> (locked && ratio_code <= 3'd1));
endmodule

bind clk_ratio_detect clk_ratio_detect_chk #(
    .PLAY_PATH (PLAY_PATH),
    .CNT_W     (CNT_W),
    .TOL       (TOL)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ratio_code  (ratio_code),
    .locked      (locked),
    .osr64       (osr64),
    .meas_valid  (meas_valid),
    .meas_period (meas_period)
);

// File: tb/clk_ratio_detect_test.sv
`timescale 1ns/1ps
module clk_ratio_detect_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fclk = 1'b0;
    logic force64 = 1'b0;

    logic [2:0] p_code, r_code;
    logic p_lock, r_lock, p_osr, r_osr, p_hold, r_hold;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    clk_ratio_detect #(.PLAY_PATH(1'b1)) uut (
        .clk(clk), .rst(rst), .frame_clk(fclk), .force_osr64(force64),
        .ratio_code(p_code), .locked(p_lock), .osr64(p_osr), .hold_req(p_hold));

    clk_ratio_detect #(.PLAY_PATH(1'b0)) uut_rec (
        .clk(clk), .rst(rst), .frame_clk(fclk), .force_osr64(force64),
        .ratio_code(r_code), .locked(r_lock), .osr64(r_osr), .hold_req(r_hold));

    function automatic int exp_code(input int p, input bit play);
        int rl[6] = '{128, 192, 256, 384, 512, 768};
        for (int i = 0; i < 6; i++) begin
            if (!play && i < 2) continue;
            if (p >= rl[i] - 32 && p <= rl[i] + 32) return i;
        end
        return 7;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic frames(input int p, input int n);
        for (int i = 0; i < n; i++) begin
            fclk = 1'b1; cycles(p / 2);
            fclk = 1'b0; cycles(p - p / 2);
        end
        fclk = 1'b1; cycles(6);
    endtask

    task automatic check_both(input int p);
        int ep, er;
        bit eo;
        ep = exp_code(p, 1'b1);
        er = exp_code(p, 1'b0);
        chk("R3 play lock", p_lock, ep != 7);
        chk("R7 play hold", p_hold, ep == 7);
        if (ep != 7) chk("R2/R4 play code", p_code, ep);
        eo = (ep == 0 || ep == 1);
        chk("R8 play osr64", p_osr, eo);
        chk("R5 rec lock", r_lock, er != 7);
        chk("R7 rec hold", r_hold, er == 7);
        if (er != 7) chk("R5 rec code", r_code, er);
        chk("R9 rec osr64", r_osr, force64);
    endtask

    initial begin
        cycles(4);
        rst = 1'b0;
        cycles(2);
        chk("R11 reset lock", p_lock, 0);
        chk("R11 reset hold", p_hold, 1);
        chk("R11 reset code", p_code, 0);
        chk("R11 reset osr64", p_osr, 0);
        chk("R11 reset rec osr64", r_osr, 0);

        // R1/R2: exact ratios.
        frames(256, 4); check_both(256);
        frames(768, 4); check_both(768);
        // R3: window edges.
        frames(96, 4);  check_both(96);
        frames(95, 4);  check_both(95);
        frames(800, 4); check_both(800);
        frames(801, 4); check_both(801);
        // R4 and R5: overlaps.
        frames(160, 4); check_both(160);
        frames(224, 4); check_both(224);
        // R8/R9: 64fs with force.
        force64 = 1'b1;
        frames(192, 4); check_both(192);
        force64 = 1'b0;
        cycles(1);
        chk("R9 rec force low", r_osr, 0);

        // R6: ratio change drops lock for one period, then relocks.
        frames(256, 4); check_both(256);
        frames(384, 1);
        chk("R6 lock drop on change", p_lock, 0);
        chk("R6 code held on change", p_code, 2);
        frames(384, 1);
        chk("R6 relock", p_lock, 1);
        chk("R6 relock code", p_code, 3);

        // R7: unmatched period keeps last code.
        frames(600, 1);
        chk("R7 unlock on bad", p_lock, 0);
        chk("R7 hold on bad", p_hold, 1);
        chk("R7 code kept", p_code, 3);

        // R10: stopped frame clock.
        frames(512, 4); check_both(512);
        fclk = 1'b0;
        cycles(1000);
        chk("R10 still locked before limit", p_lock, 1);
        cycles(100);
        chk("R10 lock drops when stopped", p_lock, 0);
        chk("R10 hold when stopped", p_hold, 1);
        chk("R10 rec lock drops", r_lock, 0);

        // Random periods around each ratio.
        void'($urandom(32'd1234));
        for (int k = 0; k < 16; k++) begin
            int rl[6] = '{128, 192, 256, 384, 512, 768};
            int p;
            p = rl[$urandom_range(5, 0)] + $urandom_range(80, 0) - 40;
            force64 = 1'($urandom_range(1, 0));
            frames(p, 4);
            check_both(p);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(190000 * 5.0);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule